// File: doc/BRIEF.md
# Bit-Serial Frame Check Sequence Generator

This block computes the frame check sequence of an HDLC-style transmitter one bit at a time. A start strobe presets the remainder register and samples a polynomial select. Each payload bit that arrives with its valid strobe then updates the remainder. The zero-bit stuffer sits downstream, so inserted zeros never reach this block. Payload bits are consumed least significant bit first.

When the transmitter reaches the end of the payload, it raises an end request. If the disable input is low in that cycle, the block shifts out the check bits, one per clock, so they can be placed ahead of the closing flag. It sends 16 or 32 bits depending on the selected polynomial. The bits leave low-order byte first, each byte least significant bit first, which is the same order as the data. If the disable input is high at the end request, nothing is appended. The disable input can change freely before the end request, so frames with and without a check sequence can be mixed.

Top module: `fcs_gen`

## Requirements
- R1: `poly_sel` selects the check type: 0 for the 16-bit CCITT polynomial 0x1021 with an all-ones preset and an inverted result, 1 for the 16-bit polynomial 0x8005 with a zero preset and no inversion, 2 for the 32-bit polynomial 0x04C11DB7 with an all-ones preset and an inverted result. Code 3 behaves like code 0.
- R2: `frame_start` presets the remainder. After that, only cycles with `bit_valid` high update it, using `bit_in`. Bits presented with `bit_valid` low have no effect.
- R3: After an accepted end request, the check bits start in the following cycle and come out one per clock on `fcs_bit`, with `fcs_valid` high. There are 16 bits for codes 0, 1 and 3, and 32 bits for code 2. They leave low-order byte first, each byte least significant bit first.
- R4: If `fcs_dis` is high in the cycle `frame_end` is accepted, no check bits are produced: `busy`, `fcs_valid` and `done` stay low.
- R5: Only the value of `fcs_dis` in the end-request cycle matters. Toggling it during the payload changes nothing.
- R6: `busy` is high for exactly the cycles in which check bits are output. `done` pulses for one cycle, together with the final check bit.
- R7: While `busy` is high, `bit_valid` and `frame_end` are ignored. `frame_start` always has priority and ends any shifting.
- R8: After reset, `busy`, `done`, `fcs_valid` and `fcs_bit` are all low.
- R9: `poly_sel` is sampled only at `frame_start`. Changing it later in the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Presets the remainder and samples the select |
| poly_sel | input | 2 | Check type code |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Payload bit, least significant bit first |
| frame_end | input | 1 | End-of-payload request |
| fcs_dis | input | 1 | Suppresses the check sequence when high at the end request |
| fcs_bit | output | 1 | Serial check bit |
| fcs_valid | output | 1 | Qualifies `fcs_bit` |
| busy | output | 1 | High while check bits are being output |
| done | output | 1 | Marks the final check bit |

## Verification
The bench runs the nine-character ASCII string "123456789" through every select code and compares the result with the published check value of each polynomial. This separates the three polynomials, their presets and their output inversions, and shows that code 3 behaves like code 0.

A bit-level model checks every output bit of empty frames, of frames with idle gaps carrying junk data, of frames where the select changes mid-frame, and of frames with disable toggles. Empty frames expose the presets directly. The gaps show that unqualified bits are skipped. The select change shows that the select is sampled only once per frame. The disable toggles show that only the value at the end request counts.

Frames that present bits and end requests while shifting, and frames that end with the disable input high, show that the shift phase cannot be disturbed and that suppression leaves every output quiet.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    SEL_CCITT = 2'd0,
    SEL_C16   = 2'd1,
    SEL_C32   = 2'd2,
    SEL_ALT   = 2'd3
  } fcs_sel_e;

  localparam int REM_W = 32;

  // reflected generator polynomials (LSB-first datapath)
  function automatic logic [REM_W-1:0] refl_poly(fcs_sel_e s);
    case (s)
      SEL_C16: return 32'h0000_A001;
      SEL_C32: return 32'hEDB8_8320;
      default: return 32'h0000_8408;
    endcase
  endfunction

  function automatic logic [REM_W-1:0] preset_of(fcs_sel_e s);
    case (s)
      SEL_C16: return 32'h0000_0000;
      SEL_C32: return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic out_inv(fcs_sel_e s);
    return (s != SEL_C16);
  endfunction

  function automatic int unsigned len_of(fcs_sel_e s);
    return (s == SEL_C32) ? 32 : 16;
  endfunction

  function automatic logic [REM_W-1:0] rem_step(logic [REM_W-1:0] c, logic b,
                                                fcs_sel_e s);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? refl_poly(s) : '0);
  endfunction
endpackage

// File: rtl/fcs_lfsr.sv
module fcs_lfsr
  import fcs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  fcs_sel_e     load_sel,
  input  fcs_sel_e     run_sel,
  input  logic         advance,
  input  logic         data_bit,
  input  logic         shift,
  output logic [W-1:0] rem_q
);
  logic [W-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)         rem_d = preset_of(load_sel);
    else if (advance) rem_d = rem_step(rem_q, data_bit, run_sel);
    else if (shift)   rem_d = rem_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= preset_of(SEL_CCITT);
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  logic [CNT_W-1:0] last_idx,
  output logic             busy,
  output logic             last_bit
);
  logic [CNT_W-1:0] cnt_q;

  assign last_bit = busy && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (last_bit) busy <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fcs_gen.sv
module fcs_gen
  import fcs_pkg::*;
#(
  parameter int FCS_MAX_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] poly_sel,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       frame_end,
  input  logic       fcs_dis,
  output logic       fcs_bit,
  output logic       fcs_valid,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(FCS_MAX_W);

  fcs_sel_e             mode_q;
  fcs_sel_e             sel_in;
  logic [REM_W-1:0]     rem_q;
  logic                 bit_take;
  logic                 end_take;
  logic                 append_go;
  logic [CNT_W-1:0]     last_idx;

  assign sel_in    = fcs_sel_e'(poly_sel);
  assign bit_take  = bit_valid && !busy && !frame_start;
  assign end_take  = frame_end && !busy && !frame_start;
  assign append_go = end_take && !fcs_dis;
  assign last_idx  = CNT_W'(len_of(mode_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= SEL_CCITT;
    else if (frame_start) mode_q <= sel_in;
  end

  fcs_lfsr #(.W(REM_W)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .load_sel (sel_in),
    .run_sel  (mode_q),
    .advance  (bit_take),
    .data_bit (bit_in),
    .shift    (busy),
    .rem_q    (rem_q)
  );

  fcs_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (frame_start),
    .go       (append_go),
    .last_idx (last_idx),
    .busy     (busy),
    .last_bit (done)
  );

  assign fcs_valid = busy;
  assign fcs_bit   = busy && (rem_q[0] ^ out_inv(mode_q));
endmodule

// File: rtl/fcs_gen_chk.sv
module fcs_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       frame_end,
  input logic       fcs_dis,
  input logic       busy,
  input logic       done,
  input logic       fcs_valid,
  input logic [1:0] mode_q
);
  logic [5:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_valid == busy);

  assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == ((mode_q == 2'd2) ? 6'd31 : 6'd15)));

  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_end && !fcs_dis && !frame_start));

  assert_dis_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && fcs_dis && !busy) |=> !busy);

  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !frame_start) |=> busy);

  assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));
endmodule

bind fcs_gen fcs_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .fcs_dis     (fcs_dis),
  .busy        (busy),
  .done        (done),
  .fcs_valid   (fcs_valid),
  .mode_q      (mode_q)
);

// File: tb/test_fcs_gen.sv
`timescale 1ns/100ps
module test_fcs_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] poly_sel = 2'd0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       frame_end = 1'b0;
  logic       fcs_dis = 1'b0;
  logic       fcs_bit, fcs_valid, busy, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int  cur_sel;
  bit  pend[$];

  always #2.5 clk = ~clk;

  fcs_gen i_fcs_gen (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: forward (MSB-first register) form
  task automatic model(input int sel, output longint fcs, output int w);
    longint poly, mask, c;
    bit inv, fb;
    w = (sel == 2) ? 32 : 16;
    mask = (longint'(1) << w) - 1;
    poly = (sel == 1) ? 64'h8005 : (sel == 2) ? 64'h04C11DB7 : 64'h1021;
    c = (sel == 1) ? 0 : mask;
    inv = (sel != 1);
    foreach (pend[i]) begin
      fb = c[w-1] ^ pend[i];
      c = (c << 1) & mask;
      if (fb) c = c ^ poly;
    end
    if (inv) c = ~c & mask;
    fcs = c;
  endtask

  task automatic start(input int sel);
    frame_start = 1'b1; poly_sel = 2'(sel);
    cur_sel = sel; pend.delete();
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic put_bit(input bit b);
    bit_valid = 1'b1; bit_in = b; pend.push_back(b);
    @(negedge clk);
    bit_valid = 1'b0;
    chk(busy == 1'b0, "R7 no busy in payload", busy, 0);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic idle_junk(input int n);
    for (int i = 0; i < n; i++) begin
      bit_in = $urandom_range(0, 1);
      @(negedge clk);
    end
  endtask

  // end frame; when junk is set, drives bits/end requests during shifting
  task automatic finish(input bit dis, input bit junk, input string req,
                        output longint got);
    longint exp; int w;
    model(cur_sel, exp, w);
    got = 0;
    frame_end = 1'b1; fcs_dis = dis;
    @(negedge clk);
    frame_end = 1'b0; fcs_dis = 1'b0;
    if (dis) begin
      for (int i = 0; i < 4; i++) begin
        chk(!busy && !done && !fcs_valid, "R4 suppressed", {busy, done, fcs_valid}, 0);
        @(negedge clk);
      end
      return;
    end
    for (int i = 0; i < w; i++) begin
      bit eb;
      eb = exp[w-1-i];
      chk(busy && fcs_valid, "R6 busy during fcs", {busy, fcs_valid}, 3);
      chk(fcs_bit == eb, req, fcs_bit, eb);
      chk(done == (i == w-1), "R6 done position", done, (i == w-1));
      got[i] = fcs_bit;
      if (junk) begin
        bit_valid = 1'b1; bit_in = ~bit_in; frame_end = i[0];
      end
      @(negedge clk);
      bit_valid = 1'b0; frame_end = 1'b0;
    end
    chk(!busy && !done, "R6 end of fcs", {busy, done}, 0);
  endtask

  task automatic check_string(input int sel, input longint known, input string req);
    longint got;
    string s;
    s = "123456789";
    start(sel);
    for (int i = 0; i < 9; i++) put_byte(s[i]);
    finish(1'b0, 1'b0, req, got);
    chk(got == known, req, got, known);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint got;
    @(negedge clk);
    chk(!busy && !done && !fcs_valid && !fcs_bit, "R8 reset state",
        {busy, done, fcs_valid, fcs_bit}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fcs_valid, "R8 after release", {busy, done, fcs_valid}, 0);

    // R1 known check values, LSB-first collected
    check_string(0, 64'h906E, "R1 ccitt check value");
    check_string(1, 64'hBB3D, "R1 crc16 check value");
    check_string(2, 64'hCBF43926, "R1 crc32 check value");
    check_string(3, 64'h906E, "R1 code3 like ccitt");

    // R3 empty frames expose presets
    for (int s = 0; s < 3; s++) begin
      start(s);
      finish(1'b0, 1'b0, "R3 empty frame", got);
    end

    // R2 gaps with junk on bit_in
    for (int s = 0; s < 3; s++) begin
      start(s);
      for (int k = 0; k < 5; k++) begin
        put_byte(8'($urandom));
        idle_junk(k);
      end
      finish(1'b0, 1'b0, "R2 gaps ignored", got);
    end

    // R9 select change mid-frame
    start(0);
    put_byte(8'hA5);
    poly_sel = 2'd2;
    put_byte(8'h3C);
    finish(1'b0, 1'b0, "R9 select sampled at start", got);
    poly_sel = 2'd0;

    // R5 disable toggled in payload, low at end
    start(2);
    fcs_dis = 1'b1; put_byte(8'h7E);
    fcs_dis = 1'b0; put_byte(8'h81);
    fcs_dis = 1'b1; put_byte(8'hFF);
    fcs_dis = 1'b0;
    finish(1'b0, 1'b0, "R5 only end value counts", got);

    // R4 disabled at end
    start(1);
    put_byte(8'h12);
    finish(1'b1, 1'b0, "R4", got);

    // R7 junk during shifting
    for (int s = 0; s < 3; s++) begin
      start(s);
      put_byte(8'hC3); put_byte(8'h5A);
      finish(1'b0, 1'b1, "R7 inputs ignored while busy", got);
    end

    // R7 frame_start aborts shifting
    start(2);
    put_byte(8'h01);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (3) @(negedge clk);
    start(0);
    chk(!busy && !done, "R7 start aborts", {busy, done}, 0);
    put_byte(8'h55);
    finish(1'b0, 1'b0, "R7 frame after abort", got);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule